// File: doc/BRIEF.md
# Timer Compare Unit with Output Actions

This block watches a free-running timer from outside and compares its count with a programmed compare value on every clock. When the two become equal, it carries out one action chosen by a 4-bit mode code. The action can toggle the compare pin, force the pin high, force it low, raise only the event flag, or issue a special event. The special event sends a one-cycle timer-reset pulse and, when conversions are enabled, a one-cycle converter-start pulse. The timer and the converter sit outside the block and are driven by those pulses.

Each stretch of equality counts as one match. The equality is registered, and the block acts only on its first cycle, so a timer that stalls on the compare value does not fire again. A mode code is held in a small state machine, `tcmp_mode_fsm`. Its states are OFF (code 0000), IDLE (reserved and non-compare codes), TOGGLE (0010), DRIVE_HI (1000), DRIVE_LO (1001), FLAG_ONLY (1010) and SPECIAL (1011). The next state always follows the decoded code, so any state can move to any other. The named transitions are enter-OFF (unit reset), enter-DRIVE_HI (pin preloaded low), enter-DRIVE_LO (pin preloaded high) and plain hold, in which the state is unchanged. The event flag stays set until software pulses the clear strobe.

Top module: `tcmp_unit`

## Requirements
- R1: After reset, cmp_pin, cmp_flag, tmr_rst_pulse and adc_start_pulse are all 0.
- R2: If tmr_val equals cmp_val before rising edge k and was unequal before edge k-1, the action takes effect at edge k+1. If the equality is held on later edges, no further action occurs until tmr_val and cmp_val have differed on at least one edge.
- R3: In mode 0010 each match inverts cmp_pin.
- R4: In mode 1000 a match drives cmp_pin to 1. On the edge where the unit enters this mode from another mode, cmp_pin is driven to 0. The entry value wins over a match on the same edge.
- R5: In mode 1001 a match drives cmp_pin to 0. On the edge where the unit enters this mode from another mode, cmp_pin is driven to 1.
- R6: In mode 1010 a match sets cmp_flag and leaves cmp_pin unchanged.
- R7: In mode 1011 a match sets cmp_flag and leaves cmp_pin unchanged. It raises tmr_rst_pulse for exactly one cycle. It raises adc_start_pulse in that same cycle only if adc_en was 1 during the match cycle. adc_start_pulse is never high without tmr_rst_pulse.
- R8: A match in any of modes 0010, 1000, 1001, 1010 and 1011 sets cmp_flag. cmp_flag stays set until flag_clr is 1 before an edge, and then it is cleared on that edge. If a match and flag_clr fall on the same edge, the flag ends set.
- R9: Mode 0000 clears cmp_pin and cmp_flag on the first edge it is seen, and it also clears the match history. If the unit leaves mode 0000 while the timer already equals the compare value, that equality counts as a new match.
- R10: Under codes 0001, 0011 and every other code not named above, a match has no effect: cmp_pin holds, cmp_flag is not set, and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_val | input | 16 | Current timer count |
| cmp_val | input | 16 | Compare value |
| mode_sel | input | 4 | Action mode code |
| adc_en | input | 1 | Allows the converter-start pulse |
| flag_clr | input | 1 | Clears the event flag when high |
| cmp_pin | output | 1 | Compare output pin |
| cmp_flag | output | 1 | Sticky match flag |
| tmr_rst_pulse | output | 1 | One-cycle timer reset request |
| adc_start_pulse | output | 1 | One-cycle conversion start request |

## Verification
Two functions can act on the event flag in the same cycle: a match that sets it and the software clear strobe. The bench first clears the flag. It then presents a one-cycle equality in the special mode and raises flag_clr exactly in the cycle where the registered match is acted on. The flag is judged set on that edge and still set two cycles later. The same match must still produce its timer-reset pulse, which shows that the clear strobe does not suppress the action.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_TOGGLE,
        ST_DRIVE_HI,
        ST_DRIVE_LO,
        ST_FLAG_ONLY,
        ST_SPECIAL
    } tcmp_state_e;

    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] CODE_OFF       = 4'b0000;
    localparam logic [MODE_W-1:0] CODE_TOGGLE    = 4'b0010;
    localparam logic [MODE_W-1:0] CODE_DRIVE_HI  = 4'b1000;
    localparam logic [MODE_W-1:0] CODE_DRIVE_LO  = 4'b1001;
    localparam logic [MODE_W-1:0] CODE_FLAG_ONLY = 4'b1010;
    localparam logic [MODE_W-1:0] CODE_SPECIAL   = 4'b1011;

    function automatic tcmp_state_e decode_mode(input logic [MODE_W-1:0] code);
        tcmp_state_e s;
        unique case (code)
            CODE_OFF:       s = ST_OFF;
            CODE_TOGGLE:    s = ST_TOGGLE;
            CODE_DRIVE_HI:  s = ST_DRIVE_HI;
            CODE_DRIVE_LO:  s = ST_DRIVE_LO;
            CODE_FLAG_ONLY: s = ST_FLAG_ONLY;
            CODE_SPECIAL:   s = ST_SPECIAL;
            default:        s = ST_IDLE;
        endcase
        return s;
    endfunction

    function automatic logic sets_flag(input tcmp_state_e s);
        return (s == ST_TOGGLE) || (s == ST_DRIVE_HI) || (s == ST_DRIVE_LO) ||
               (s == ST_FLAG_ONLY) || (s == ST_SPECIAL);
    endfunction

endpackage

// File: rtl/tcmp_match_det.sv
module tcmp_match_det #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [TMR_W-1:0] tmr,
    input  logic [TMR_W-1:0] cmp,
    output logic             hit
);

    logic eq_now;
    logic eq_q;
    logic eq_prev;

    assign eq_now = (tmr == cmp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eq_q    <= 1'b0;
            eq_prev <= 1'b0;
        end else if (clear) begin
            eq_q    <= 1'b0;
            eq_prev <= 1'b0;
        end else begin
            eq_q    <= eq_now;
            eq_prev <= eq_q;
        end
    end

    assign hit = eq_q & ~eq_prev;

    // R2
    single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);

    // R2
    hit_follows_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eq_now && !clear && !eq_q) |=> hit);

endmodule

// File: rtl/tcmp_mode_fsm.sv
module tcmp_mode_fsm
    import tcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_sel,
    output tcmp_state_e       state,
    output tcmp_state_e       next_state
);

    always_comb begin
        next_state = decode_mode(mode_sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= next_state;
        end
    end

    // R9
    off_tracks_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == CODE_OFF) |=> (state == ST_OFF));

endmodule

// File: rtl/tcmp_action.sv
module tcmp_action
    import tcmp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  tcmp_state_e state,
    input  tcmp_state_e next_state,
    input  logic        hit,
    input  logic        adc_en,
    input  logic        flag_clr,
    output logic        pin,
    output logic        flag,
    output logic        trst,
    output logic        adc_go
);

    logic entering;
    logic flag_set;

    assign entering = (next_state != state);
    assign flag_set = hit & sets_flag(state);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin    <= 1'b0;
            flag   <= 1'b0;
            trst   <= 1'b0;
            adc_go <= 1'b0;
        end else begin
            trst   <= 1'b0;
            adc_go <= 1'b0;
            if (next_state == ST_OFF) begin
                pin  <= 1'b0;
                flag <= 1'b0;
            end else begin
                if (flag_set) begin
                    flag <= 1'b1;
                end else if (flag_clr) begin
                    flag <= 1'b0;
                end

                if (entering && next_state == ST_DRIVE_HI) begin
                    pin <= 1'b0;
                end else if (entering && next_state == ST_DRIVE_LO) begin
                    pin <= 1'b1;
                end else if (hit) begin
                    unique case (state)
                        ST_TOGGLE:   pin <= ~pin;
                        ST_DRIVE_HI: pin <= 1'b1;
                        ST_DRIVE_LO: pin <= 1'b0;
                        default:     pin <= pin;
                    endcase
                end

                if (hit && state == ST_SPECIAL) begin
                    trst   <= 1'b1;
                    adc_go <= adc_en;
                end
            end
        end
    end

    // R7
    trst_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trst |=> !trst);

    // R7
    adc_with_trst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_go |-> trst);

    // R6
    flag_only_pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLAG_ONLY && next_state == ST_FLAG_ONLY) |=> $stable(pin));

    // R10
    idle_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && next_state == ST_IDLE) |=> ($stable(pin) && !trst && !$rose(flag)));

    // R8
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && sets_flag(state) && next_state != ST_OFF) |=> flag);

    // R9
    off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (next_state == ST_OFF) |=> (!pin && !flag));

    // R4
    drive_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && state == ST_DRIVE_HI && next_state == ST_DRIVE_HI) |=> pin);

    // R5
    drive_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && state == ST_DRIVE_LO && next_state == ST_DRIVE_LO) |=> !pin);

endmodule

// File: rtl/tcmp_unit.sv
module tcmp_unit
    import tcmp_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMR_W-1:0] tmr_val,
    input  logic [TMR_W-1:0] cmp_val,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic             adc_en,
    input  logic             flag_clr,
    output logic             cmp_pin,
    output logic             cmp_flag,
    output logic             tmr_rst_pulse,
    output logic             adc_start_pulse
);

    tcmp_state_e state;
    tcmp_state_e next_state;
    logic        hit;
    logic        det_clear;

    assign det_clear = (next_state == ST_OFF);

    tcmp_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel   (mode_sel),
        .state      (state),
        .next_state (next_state)
    );

    tcmp_match_det #(.TMR_W(TMR_W)) u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (det_clear),
        .tmr   (tmr_val),
        .cmp   (cmp_val),
        .hit   (hit)
    );

    tcmp_action u_act (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .next_state (next_state),
        .hit        (hit),
        .adc_en     (adc_en),
        .flag_clr   (flag_clr),
        .pin        (cmp_pin),
        .flag       (cmp_flag),
        .trst       (tmr_rst_pulse),
        .adc_go     (adc_start_pulse)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!tmr_rst_pulse && !adc_start_pulse));

endmodule

// File: tb/tcmp_unit_test.sv
module tcmp_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int SIG_PIN  = 0;
    localparam int SIG_FLAG = 1;
    localparam int SIG_TRST = 2;
    localparam int SIG_ADC  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tmr_val = 16'd0;
    logic [15:0] cmp_val = 16'd5;
    logic [3:0]  mode_sel = 4'b0000;
    logic        adc_en = 1'b0;
    logic        flag_clr = 1'b0;
    logic        cmp_pin, cmp_flag, tmr_rst_pulse, adc_start_pulse;

    typedef struct {
        int    cyc;
        int    sig;
        bit    val;
        string req;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    tcmp_unit uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .tmr_val         (tmr_val),
        .cmp_val         (cmp_val),
        .mode_sel        (mode_sel),
        .adc_en          (adc_en),
        .flag_clr        (flag_clr),
        .cmp_pin         (cmp_pin),
        .cmp_flag        (cmp_flag),
        .tmr_rst_pulse   (tmr_rst_pulse),
        .adc_start_pulse (adc_start_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic bit pick(int s);
        case (s)
            SIG_PIN:  return cmp_pin;
            SIG_FLAG: return cmp_flag;
            SIG_TRST: return tmr_rst_pulse;
            default:  return adc_start_pulse;
        endcase
    endfunction

    // driver side: expectation d cycles after the current negedge
    task automatic expect_in(int d, int s, bit v, string r);
        exp_t e;
        int   i;
        e.cyc = cyc + d; e.sig = s; e.val = v; e.req = r;
        i = 0;
        while (i < q.size() && q[i].cyc <= e.cyc) i++;
        q.insert(i, e);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic one_match();
        tmr_val = cmp_val;
        tick(1);
        tmr_val = cmp_val + 16'd1;
    endtask

    task automatic pulse_clear();
        flag_clr = 1'b1;
        expect_in(1, SIG_FLAG, 1'b0, "R8");
        tick(1);
        flag_clr = 1'b0;
        tick(1);
    endtask

    // monitor side
    always @(negedge clk) begin
        #1;
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            exp_t e;
            bit   act;
            e = q.pop_front();
            act = pick(e.sig);
            n_chk++;
            if (e.cyc != cyc || act != e.val) begin
                n_bad++;
                $display("FAIL %s sig%0d cycle %0d: actual %0b expected %0b",
                         e.req, e.sig, cyc, act, e.val);
            end
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        // R1
        expect_in(1, SIG_PIN, 1'b0, "R1");
        expect_in(1, SIG_FLAG, 1'b0, "R1");
        expect_in(1, SIG_TRST, 1'b0, "R1");
        expect_in(1, SIG_ADC, 1'b0, "R1");
        tick(2);

        // toggle mode, held equality (R2, R3, R8)
        mode_sel = 4'b0010;
        tick(2);
        tmr_val = 16'd5;
        expect_in(1, SIG_PIN, 1'b0, "R2");
        expect_in(2, SIG_PIN, 1'b1, "R3");
        expect_in(2, SIG_FLAG, 1'b1, "R8");
        expect_in(5, SIG_PIN, 1'b1, "R2");
        expect_in(5, SIG_FLAG, 1'b1, "R8");
        tick(6);
        tmr_val = 16'd0;
        tick(2);
        pulse_clear();
        expect_in(2, SIG_PIN, 1'b0, "R3");
        expect_in(2, SIG_FLAG, 1'b1, "R8");
        one_match();
        tick(3);
        expect_in(2, SIG_PIN, 1'b1, "R3");
        one_match();
        tick(3);

        // drive-high mode with entry preload (R4)
        mode_sel = 4'b1000;
        expect_in(1, SIG_PIN, 1'b0, "R4");
        tick(3);
        expect_in(2, SIG_PIN, 1'b1, "R4");
        one_match();
        tick(3);

        // flag-only mode (R6)
        mode_sel = 4'b1010;
        tick(2);
        pulse_clear();
        expect_in(2, SIG_FLAG, 1'b1, "R6");
        expect_in(2, SIG_PIN, 1'b1, "R6");
        expect_in(3, SIG_PIN, 1'b1, "R6");
        one_match();
        tick(3);

        // off mode (R9)
        mode_sel = 4'b0000;
        expect_in(1, SIG_PIN, 1'b0, "R9");
        expect_in(1, SIG_FLAG, 1'b0, "R9");
        tick(2);

        // drive-low mode with entry preload (R5)
        mode_sel = 4'b1001;
        expect_in(1, SIG_PIN, 1'b1, "R5");
        tick(3);
        expect_in(2, SIG_PIN, 1'b0, "R5");
        expect_in(2, SIG_FLAG, 1'b1, "R5");
        one_match();
        tick(3);

        // special event, converter disabled then enabled (R7)
        mode_sel = 4'b1011;
        adc_en = 1'b0;
        tick(2);
        expect_in(2, SIG_TRST, 1'b1, "R7");
        expect_in(2, SIG_ADC, 1'b0, "R7");
        expect_in(2, SIG_PIN, 1'b0, "R7");
        expect_in(3, SIG_TRST, 1'b0, "R7");
        one_match();
        tick(4);
        adc_en = 1'b1;
        expect_in(2, SIG_TRST, 1'b1, "R7");
        expect_in(2, SIG_ADC, 1'b1, "R7");
        expect_in(3, SIG_ADC, 1'b0, "R7");
        expect_in(3, SIG_TRST, 1'b0, "R7");
        one_match();
        tick(4);
        adc_en = 1'b0;

        // match and clear strobe on the same edge (R8)
        pulse_clear();
        expect_in(2, SIG_FLAG, 1'b1, "R8");
        expect_in(2, SIG_TRST, 1'b1, "R8");
        expect_in(4, SIG_FLAG, 1'b1, "R8");
        tmr_val = cmp_val;
        tick(1);
        tmr_val = cmp_val + 16'd1;
        flag_clr = 1'b1;
        tick(1);
        flag_clr = 1'b0;
        tick(3);

        // reserved code: no effect (R10)
        mode_sel = 4'b0011;
        tick(2);
        pulse_clear();
        expect_in(2, SIG_FLAG, 1'b0, "R10");
        expect_in(2, SIG_TRST, 1'b0, "R10");
        expect_in(2, SIG_PIN, 1'b0, "R10");
        expect_in(3, SIG_FLAG, 1'b0, "R10");
        tmr_val = cmp_val;
        tick(4);

        // off clears match history while equality is held (R9)
        mode_sel = 4'b0000;
        tick(2);
        mode_sel = 4'b0010;
        expect_in(1, SIG_PIN, 1'b0, "R9");
        expect_in(2, SIG_PIN, 1'b1, "R9");
        expect_in(2, SIG_FLAG, 1'b1, "R9");
        tick(4);
        tmr_val = 16'd0;
        tick(3);

        if (q.size() != 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL queue: actual %0d pending expected 0", q.size());
        end
        done = 1'b1;
        finish_run();
    end

endmodule